// File: doc/BRIEF.md
# Sequenced Write-Protection Register Unlock

This block keeps two critical control registers, one for power-save control and one for processor clock control, safe from stray stores. Software must first write any value to a command register. That write arms the block. The next bus access must then be the write to the protected register. Any other ordering drops the protected write and latches a sticky protection-error flag in a status register. Software clears the flag by writing 0 to it.

The block sits on a simple synchronous register bus. Each cycle with a read or write strobe is one access. Cycles with neither strobe are not accesses and leave the arming alone. A read-modify-write, as issued by a bit set, clear or invert, appears on the bus as a read of the protected register followed by a write to it. The sequencer accepts that pair as the single step that follows the command write.

The sequencer has four states:
- `ST_IDLE`: disarmed.
- `ST_ARMED`: a command write was seen.
- `ST_HOLD_PWR`: armed, and the power register has just been read as the first half of a read-modify-write.
- `ST_HOLD_CLK`: the same, for the clock register.

Transitions:
- Any state goes to `ST_ARMED` on a command write.
- `ST_ARMED` goes to a hold state on a read of the matching protected register.
- Any other access from `ST_ARMED` or from a hold state returns to `ST_IDLE`.
- Idle bus cycles keep the current state.
- Reset enters `ST_IDLE`.

Top module: `wprot_unit`

## Requirements
- R1: After reset the power register reads 0x00, the clock register reads 0x03, the status register reads 0x00, and the block is disarmed, so a protected write as the first access after reset is dropped.
- R2: A write of any 8-bit value to the command register (address 0) arms the block. A write to the power register (address 1) or the clock register (address 2) as the next access takes the written value.
- R3: A write to a protected register while disarmed leaves that register unchanged and sets status bit 0 (the protection-error flag).
- R4: After a command write, any other read or write (for example a status access) ends the armed state. A following protected write is dropped and sets the error flag.
- R5: Cycles with neither strobe asserted are not accesses. The armed state survives them.
- R6: A read of a protected register while armed, followed by a write to the same register as the next access, completes the write. If that next write targets the other protected register, the write is dropped and the error flag is set.
- R7: The protected registers can be read at any time without unlocking, and reading does not change them. Read data appears on `bus_rdata` one clock after the read strobe and is held until the next read.
- R8: The error flag is sticky. Writing the status register with bit 0 clear clears it. Writing with bit 0 set has no effect. A correctly sequenced write never sets it.
- R9: The command register reads 0x00. A second command write while armed re-arms the block for the next access.
- R10: The status register (address 3) reads the error flag in bit 0 and zeros in bits 7:1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe (has priority when both are set) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pwr_ctrl | output | 8 | Current power-save control value |
| clk_ctrl | output | 8 | Current clock control value |

## Verification
Every state change, register update and error-flag change takes effect at the clock edge that samples the access. A read returns its data on `bus_rdata` at the edge that samples the read strobe. The bench drives each access on the falling edge and samples one time unit after the following rising edge. Writes are therefore judged by a later read, and each read's expected value is already valid at its own sample point. Directed cases check `pwr_ctrl` and `clk_ctrl` directly at the same offset after the edge.

// File: rtl/wprot_pkg.sv
package wprot_pkg;
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_ARMED    = 2'd1,
        ST_HOLD_PWR = 2'd2,
        ST_HOLD_CLK = 2'd3
    } wp_state_t;
endpackage

// File: rtl/wprot_seq.sv
module wprot_seq
    import wprot_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_i,
    input  logic wr_i,
    input  logic hit_cmd_i,
    input  logic hit_pwr_i,
    input  logic hit_clk_i,
    output logic grant_pwr_o,
    output logic grant_clk_o,
    output logic viol_o
);
    wp_state_t state_q, state_d;
    logic      acc_any, acc_rd, ok_pwr, ok_clk;

    assign acc_any = rd_i | wr_i;
    assign acc_rd  = rd_i & ~wr_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_i && hit_cmd_i) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (wr_i && hit_cmd_i)        state_d = ST_ARMED;
                else if (acc_rd && hit_pwr_i) state_d = ST_HOLD_PWR;
                else if (acc_rd && hit_clk_i) state_d = ST_HOLD_CLK;
                else if (acc_any)             state_d = ST_IDLE;
            end
            ST_HOLD_PWR, ST_HOLD_CLK: begin
                if (wr_i && hit_cmd_i) state_d = ST_ARMED;
                else if (acc_any)      state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ok_pwr      = (state_q == ST_ARMED) || (state_q == ST_HOLD_PWR);
        ok_clk      = (state_q == ST_ARMED) || (state_q == ST_HOLD_CLK);
        grant_pwr_o = wr_i & hit_pwr_i & ok_pwr;
        grant_clk_o = wr_i & hit_clk_i & ok_clk;
        viol_o      = wr_i & ((hit_pwr_i & ~ok_pwr) | (hit_clk_i & ~ok_clk));
    end

    // R2
    arm_on_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && hit_cmd_i) |=> (state_q == ST_ARMED));

    // R4
    one_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && rd_i && !wr_i && !hit_pwr_i && !hit_clk_i)
        |=> (state_q == ST_IDLE));
endmodule

// File: rtl/wprot_regs.sv
module wprot_regs
    import wprot_pkg::*;
#(
    parameter logic [DATA_W-1:0] PWR_RST = 8'h00,
    parameter logic [DATA_W-1:0] CLK_RST = 8'h03
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              hit_pwr_i,
    input  logic              hit_clk_i,
    input  logic              hit_stat_i,
    input  logic              grant_pwr_i,
    input  logic              grant_clk_i,
    input  logic              viol_i,
    output logic [DATA_W-1:0] pwr_o,
    output logic [DATA_W-1:0] clk_o,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DATA_W-1:0] pwr_q, clkr_q, rdata_q, rd_mux;
    logic              err_q, stat_clr;

    assign stat_clr = wr_i & hit_stat_i & ~wdata_i[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwr_q  <= PWR_RST;
            clkr_q <= CLK_RST;
            err_q  <= 1'b0;
        end else begin
            if (grant_pwr_i) pwr_q  <= wdata_i;
            if (grant_clk_i) clkr_q <= wdata_i;
            if (viol_i)        err_q <= 1'b1;
            else if (stat_clr) err_q <= 1'b0;
        end
    end

    always_comb begin
        rd_mux = '0;
        if (hit_pwr_i)       rd_mux = pwr_q;
        else if (hit_clk_i)  rd_mux = clkr_q;
        else if (hit_stat_i) rd_mux = {{(DATA_W-1){1'b0}}, err_q};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    rdata_q <= '0;
        else if (rd_i) rdata_q <= rd_mux;
    end

    assign pwr_o   = pwr_q;
    assign clk_o   = clkr_q;
    assign rdata_o = rdata_q;

    // R3
    pwr_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pwr_q) |-> $past(grant_pwr_i));

    // R3
    viol_sets_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol_i |=> err_q);

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !(wr_i && hit_stat_i && !wdata_i[0])) |=> err_q);
endmodule

// File: rtl/wprot_unit.sv
module wprot_unit
    import wprot_pkg::*;
#(
    parameter int                ADDR_W    = 2,
    parameter int                CMD_ADDR  = 0,
    parameter int                PWR_ADDR  = 1,
    parameter int                CLK_ADDR  = 2,
    parameter int                STAT_ADDR = 3,
    parameter logic [DATA_W-1:0] PWR_RST   = 8'h00,
    parameter logic [DATA_W-1:0] CLK_RST   = 8'h03
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] pwr_ctrl,
    output logic [DATA_W-1:0] clk_ctrl
);
    logic hit_cmd, hit_pwr, hit_clk, hit_stat;
    logic grant_pwr, grant_clk, viol;

    assign hit_cmd  = (bus_addr == ADDR_W'(CMD_ADDR));
    assign hit_pwr  = (bus_addr == ADDR_W'(PWR_ADDR));
    assign hit_clk  = (bus_addr == ADDR_W'(CLK_ADDR));
    assign hit_stat = (bus_addr == ADDR_W'(STAT_ADDR));

    wprot_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_i        (bus_rd),
        .wr_i        (bus_wr),
        .hit_cmd_i   (hit_cmd),
        .hit_pwr_i   (hit_pwr),
        .hit_clk_i   (hit_clk),
        .grant_pwr_o (grant_pwr),
        .grant_clk_o (grant_clk),
        .viol_o      (viol)
    );

    wprot_regs #(
        .PWR_RST (PWR_RST),
        .CLK_RST (CLK_RST)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_i        (bus_rd),
        .wr_i        (bus_wr),
        .wdata_i     (bus_wdata),
        .hit_pwr_i   (hit_pwr),
        .hit_clk_i   (hit_clk),
        .hit_stat_i  (hit_stat),
        .grant_pwr_i (grant_pwr),
        .grant_clk_i (grant_clk),
        .viol_i      (viol),
        .pwr_o       (pwr_ctrl),
        .clk_o       (clk_ctrl),
        .rdata_o     (bus_rdata)
    );
endmodule

// File: tb/wprot_unit_tb.sv
`timescale 1ns/1ps
module wprot_unit_tb_top;
    // vector: [23] rd [22] wr [21:20] addr [19:12] wdata [11:4] expected [3:0] requirement
    function automatic logic [23:0] rv(input logic [1:0] a, input logic [7:0] e, input logic [3:0] r);
        return {1'b1, 1'b0, a, 8'h00, e, r};
    endfunction
    function automatic logic [23:0] wv(input logic [1:0] a, input logic [7:0] d);
        return {1'b0, 1'b1, a, d, 8'h00, 4'd0};
    endfunction
    function automatic logic [23:0] iv();
        return 24'h0;
    endfunction

    localparam logic [1:0] A_CMD = 2'd0, A_PWR = 2'd1, A_CLK = 2'd2, A_ST = 2'd3;
    localparam int NV = 46;
    localparam logic [23:0] TBL [NV] = '{
        rv(A_PWR, 8'h00, 4'd1),   // R1 reset value
        rv(A_CLK, 8'h03, 4'd1),   // R1
        rv(A_ST,  8'h00, 4'd1),   // R1
        wv(A_PWR, 8'h55),
        rv(A_PWR, 8'h00, 4'd3),   // R3 dropped
        rv(A_ST,  8'h01, 4'd3),   // R3 flagged
        wv(A_ST,  8'h01),
        rv(A_ST,  8'h01, 4'd8),   // R8 writing 1 has no effect
        wv(A_ST,  8'h00),
        rv(A_ST,  8'h00, 4'd8),   // R8 cleared
        wv(A_CMD, 8'hA5),
        wv(A_PWR, 8'h5A),
        rv(A_PWR, 8'h5A, 4'd2),   // R2
        rv(A_ST,  8'h00, 4'd8),   // R8 good write sets nothing
        wv(A_CMD, 8'h00),
        iv(),
        iv(),
        wv(A_CLK, 8'h0C),
        rv(A_CLK, 8'h0C, 4'd5),   // R5 idle cycles keep arming
        wv(A_CMD, 8'hFF),
        rv(A_ST,  8'h00, 4'd10),  // R10 status format
        wv(A_CLK, 8'h33),
        rv(A_CLK, 8'h0C, 4'd4),   // R4 intervening read
        rv(A_ST,  8'h01, 4'd4),   // R4
        wv(A_ST,  8'hFE),
        rv(A_ST,  8'h00, 4'd8),   // R8
        wv(A_CMD, 8'h11),
        wv(A_CMD, 8'h22),
        wv(A_PWR, 8'h77),
        rv(A_PWR, 8'h77, 4'd9),   // R9 re-arm
        rv(A_CMD, 8'h00, 4'd9),   // R9 command reads 0
        wv(A_CMD, 8'h01),
        rv(A_CLK, 8'h0C, 4'd7),   // R7 read while armed
        wv(A_CLK, 8'h0D),
        rv(A_CLK, 8'h0D, 4'd6),   // R6 read-modify-write
        rv(A_ST,  8'h00, 4'd6),   // R6
        wv(A_CMD, 8'h01),
        rv(A_PWR, 8'h77, 4'd7),   // R7
        wv(A_CLK, 8'h99),
        rv(A_CLK, 8'h0D, 4'd6),   // R6 mismatched target
        rv(A_ST,  8'h01, 4'd6),   // R6
        wv(A_CMD, 8'h00),
        wv(A_ST,  8'h00),
        wv(A_PWR, 8'h12),
        rv(A_PWR, 8'h77, 4'd4),   // R4 intervening write
        rv(A_ST,  8'h01, 4'd4)    // R4
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata, pwr_ctrl, clk_ctrl;
    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    wprot_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwr_ctrl  (pwr_ctrl),
        .clk_ctrl  (clk_ctrl)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input int req);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL R%0d actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [23:0] v);
        @(negedge clk);
        bus_rd    = v[23];
        bus_wr    = v[22];
        bus_addr  = v[21:20];
        bus_wdata = v[19:12];
        @(posedge clk);
        #1;
        if (v[23]) check(bus_rdata, v[11:4], int'(v[3:0]));
        @(negedge clk);
        bus_rd = 1'b0;
        bus_wr = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(pwr_ctrl, 8'h00, 1);  // R1
        check(clk_ctrl, 8'h03, 1);  // R1
        check(bus_rdata, 8'h00, 1); // R1
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) apply(TBL[i]);

        // R2 output port follows a sequenced write
        apply(wv(A_CMD, 8'h3C));
        apply(wv(A_PWR, 8'hC3));
        check(pwr_ctrl, 8'hC3, 2);
        // R1 reset while armed leaves the block disarmed
        apply(wv(A_CMD, 8'h00));
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check(pwr_ctrl, 8'h00, 1);
        @(negedge clk);
        rst_n = 1'b1;
        apply(wv(A_PWR, 8'hEE));
        check(pwr_ctrl, 8'h00, 1);
        apply(rv(A_ST, 8'h01, 4'd1));
        check(clk_ctrl, 8'h03, 1);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule